// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block gives a small 8-bit CPU three general-purpose I/O ports through its data-memory bus. Port A is 4 pins wide. Ports B and C are 8 pins wide each. Each port has an output latch that the CPU writes at a fixed data address. A read of that same address returns the synchronised levels on the port's pins. Each port also has three configuration registers, all active-low: pin direction, input threshold select and weak pull-up enable.

The configuration registers have no bus addresses of their own. The CPU first loads a 2-bit mode register to pick the register kind. It then issues a configuration write that names a port, and the write data goes into the chosen register of that port. After reset every configuration bit is one. So every pin starts as a Hi-Z input with TTL thresholds and no pull-up. The mode starts at "none", which blocks configuration writes until software picks a mode.

Pins are packed into 20-bit vectors. Port A occupies bits 3:0, port B bits 11:4 and port C bits 19:12. Within each port, register bit 0 maps to the lowest pin.

Top module: `gpio_ports`

## Requirements
- R1: After reset, pin_out_o is all zeros, pin_oe_o is all zeros (every pin a Hi-Z input), pin_ttl_o is all ones, pin_pu_n_o is all ones (pull-ups off), and the mode is none.
- R2: A cycle with wr_en_i high and addr_i at 05h, 06h or 07h loads wdata_i into the output latch of port A, B or C. The new value shows on that port's pin_out_o bits after the next rising clock edge. Writes to any other address change no output.
- R3: Port A is 4 bits wide. A data write to port A uses wdata_i[3:0] and ignores wdata_i[7:4].
- R4: A cycle with mode_we_i high loads wdata_i[1:0] into the mode register. The encoding is 00 none, 01 direction, 10 level, 11 pull-up.
- R5: A cycle with cfg_we_i high and cfg_sel_i at 0, 1 or 2 stores wdata_i into the register chosen by the mode, for port A, B or C. The result is visible after the next edge. In the direction register, bit 0 makes the pin an output, so pin_oe_o is high. In the level register, bit 1 selects TTL and drives pin_ttl_o high. In the pull-up register, bit 0 enables the pull-up and drives pin_pu_n_o low.
- R6: A configuration write has no effect in two cases: while the mode is none, or when cfg_sel_i is 3.
- R7: Reading address 05h, 06h or 07h returns, in the same cycle, that port's pin_i levels as sampled two rising edges earlier. Unused port A bits read as 0, and every other address reads as 0.
- R8: The output latch holds its value whatever the pin direction. Turning a pin into an output does not change pin_out_o, so the pin drives the stored value.
- R9: When mode_we_i and cfg_we_i are both high in one cycle, the configuration write uses the mode held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Data-memory address for data reads and writes |
| wdata_i | input | 8 | Write data for data, mode and configuration writes |
| wr_en_i | input | 1 | Data register write strobe |
| mode_we_i | input | 1 | Mode register write strobe |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_sel_i | input | 2 | Port targeted by a configuration write (0 A, 1 B, 2 C, 3 none) |
| rdata_o | output | 8 | Read data for addr_i |
| pin_i | input | 20 | Pin input levels |
| pin_out_o | output | 20 | Output latch values |
| pin_oe_o | output | 20 | Output enable per pin (high drives the pin) |
| pin_ttl_o | output | 20 | Threshold select per pin (1 TTL, 0 CMOS) |
| pin_pu_n_o | output | 20 | Pull-up control per pin (0 enables) |

## Verification
The block's internal state is its output latches, its configuration registers and its mode register. All of the latch and configuration state is visible directly on the pin vectors. A wrong latch or configuration bit therefore shows up on pin_out_o, pin_oe_o, pin_ttl_o or pin_pu_n_o one edge after the write that caused it. A wrong mode value shows up through the next configuration write, which either lands in the wrong register or is dropped. A fault in the synchroniser shows on rdata_o as a value that arrives one cycle early, one cycle late or on the wrong bits, two edges after the pin changes.

// File: rtl/gpio_ports_pkg.sv
package gpio_ports_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_DIR  = 2'b01,
    MODE_LVL  = 2'b10,
    MODE_PULL = 2'b11
  } cfg_mode_e;

  localparam int NUM_PORTS = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= din_i;
      sync_q <= meta_q;
    end
  end

  assign dout_o = sync_q;

  // checker only: edges since reset, saturating at 2
  logic [1:0] edges_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               edges_q <= '0;
    else if (edges_q != 2'd2)  edges_q <= edges_q + 2'd1;
  end

  // R7
  sync_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q == 2'd2) |-> (dout_o == $past(din_i, 2)));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_ports_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         data_we_i,
  input  logic         cfg_we_i,
  input  cfg_mode_e    mode_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] out_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] pu_n_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_o <= '0;
    else if (data_we_i) out_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '1;
      lvl_o  <= '1;
      pu_n_o <= '1;
    end else if (cfg_we_i) begin
      case (mode_i)
        MODE_DIR:  dir_o  <= wdata_i;
        MODE_LVL:  lvl_o  <= wdata_i;
        MODE_PULL: pu_n_o <= wdata_i;
        default:   ;
      endcase
    end
  end

  // R2
  data_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i |=> (out_o == $past(wdata_i)));

  // R8
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_we_i |=> $stable(out_o));

  // R5
  dir_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && mode_i == MODE_DIR) |=> (dir_o == $past(wdata_i)));

  // R6
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i || mode_i == MODE_NONE) |=>
      ($stable(dir_o) && $stable(lvl_o) && $stable(pu_n_o)));
endmodule

// File: rtl/gpio_ports.sv
module gpio_ports
  import gpio_ports_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int PA_W      = 4,
  parameter int PB_W      = 8,
  parameter int PC_W      = 8,
  parameter int BASE_ADDR = 5,
  localparam int NPINS    = PA_W + PB_W + PC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_en_i,
  input  logic              mode_we_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_out_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic [NPINS-1:0]  pin_ttl_o,
  output logic [NPINS-1:0]  pin_pu_n_o
);
  cfg_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_NONE;
    else if (mode_we_i) mode_q <= cfg_mode_e'(wdata_i[1:0]);
  end

  logic [NUM_PORTS-1:0][DATA_W-1:0] rd_vec;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    localparam int W  = (g == 0) ? PA_W : (g == 1) ? PB_W : PC_W;
    localparam int LO = (g == 0) ? 0 : (g == 1) ? PA_W : PA_W + PB_W;

    logic         data_we, cfg_we;
    logic [W-1:0] out_q, dir_q, lvl_q, pu_q, sync_q;

    assign data_we = wr_en_i && (addr_i == ADDR_W'(BASE_ADDR + g));
    assign cfg_we  = cfg_we_i && (cfg_sel_i == 2'(g));

    gpio_port_regs #(.W(W)) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .data_we_i (data_we),
      .cfg_we_i  (cfg_we),
      .mode_i    (mode_q),
      .wdata_i   (wdata_i[W-1:0]),
      .out_o     (out_q),
      .dir_o     (dir_q),
      .lvl_o     (lvl_q),
      .pu_n_o    (pu_q)
    );

    gpio_sync #(.W(W)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (pin_i[LO +: W]),
      .dout_o (sync_q)
    );

    assign pin_out_o[LO +: W]  = out_q;
    assign pin_oe_o[LO +: W]   = ~dir_q;
    assign pin_ttl_o[LO +: W]  = lvl_q;
    assign pin_pu_n_o[LO +: W] = pu_q;
    assign rd_vec[g]           = DATA_W'(sync_q);
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (addr_i == ADDR_W'(BASE_ADDR + p)) rdata_o = rd_vec[p];
  end

  // R4
  mode_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> (mode_q == cfg_mode_e'($past(wdata_i[1:0]))));

  // R3
  port_a_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(BASE_ADDR)) |=>
      (pin_out_o[PA_W-1:0] == $past(wdata_i[PA_W-1:0])));
endmodule

// File: tb/gpio_ports_test.sv
module gpio_ports_test;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  addr = 0, wdata = 0;
  logic        wr_en = 0, mode_we = 0, cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [7:0]  rdata;
  logic [19:0] pin = 0, pout, poe, pttl, ppu;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [19:0] e_out = '0, e_dir = '1, e_ttl = '1, e_pu = '1, e_sync = '0;
  logic [1:0]  e_mode = 0;

  always #10 clk = ~clk;

  gpio_ports uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .mode_we_i(mode_we), .cfg_we_i(cfg_we),
    .cfg_sel_i(cfg_sel), .rdata_o(rdata), .pin_i(pin),
    .pin_out_o(pout), .pin_oe_o(poe), .pin_ttl_o(pttl), .pin_pu_n_o(ppu)
  );

  function automatic int plo(int p); return (p == 0) ? 0 : (p == 1) ? 4 : 12; endfunction
  function automatic int pw(int p);  return (p == 0) ? 4 : 8; endfunction

  task automatic check(string tag, logic [79:0] act, logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_pins(string tag);
    check(tag, {pout, poe, pttl, ppu}, {e_out, ~e_dir, e_ttl, e_pu});
  endtask

  task automatic apply_cfg(int sel, logic [7:0] d);
    if (sel < 3 && e_mode != 2'b00)
      for (int i = 0; i < pw(sel); i++)
        case (e_mode)
          2'b01:   e_dir[plo(sel)+i] = d[i];
          2'b10:   e_ttl[plo(sel)+i] = d[i];
          default: e_pu[plo(sel)+i]  = d[i];
        endcase
  endtask

  task automatic data_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    if (a >= 8'h05 && a <= 8'h07)
      for (int i = 0; i < pw(a - 5); i++) e_out[plo(a - 5)+i] = d[i];
  endtask

  task automatic mode_write(logic [1:0] m);
    @(negedge clk); wdata = {6'b0, m}; mode_we = 1;
    @(negedge clk); mode_we = 0;
    e_mode = m;
  endtask

  task automatic cfg_write(int sel, logic [7:0] d);
    @(negedge clk); wdata = d; cfg_sel = 2'(sel); cfg_we = 1;
    @(negedge clk); cfg_we = 0;
    apply_cfg(sel, d);
  endtask

  function automatic logic [7:0] port_slice(logic [19:0] v, int p);
    logic [7:0] r = '0;
    for (int i = 0; i < pw(p); i++) r[i] = v[plo(p)+i];
    return r;
  endfunction

  task automatic pin_read(int p, logic [7:0] v);
    logic [19:0] nxt = e_sync;
    for (int i = 0; i < pw(p); i++) nxt[plo(p)+i] = v[i];
    @(negedge clk); pin = nxt; addr = 8'(5 + p);
    @(negedge clk);
    check("R7 one edge: old value", {72'b0, rdata}, {72'b0, port_slice(e_sync, p)});
    @(negedge clk);
    e_sync = nxt;
    check("R7 two edges: new value", {72'b0, rdata}, {72'b0, port_slice(e_sync, p)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_pins("R1 reset pins");
    for (int p = 0; p < 3; p++) begin
      addr = 8'(5 + p); #1;
      check("R1 reset read", {72'b0, rdata}, 80'b0);
    end

    // R6 mode none blocks configuration
    for (int p = 0; p < 3; p++) begin
      cfg_write(p, 8'h00);
      check_pins("R6 mode none ignored");
    end

    // R2 R3 data latch sweeps
    for (int p = 0; p < 3; p++)
      for (int v = 0; v < 256; v++) begin
        data_write(8'(5 + p), 8'(v));
        check_pins(p == 0 ? "R3 port A data" : "R2 data write");
      end

    // R2 other addresses ignored
    for (int a = 0; a < 256; a++)
      if (a < 5 || a > 7) begin
        data_write(8'(a), 8'h96);
        check_pins("R2 foreign address");
      end

    // R4 R5 config sweeps in every mode
    for (int m = 1; m < 4; m++) begin
      mode_write(2'(m));
      for (int p = 0; p < 3; p++)
        for (int v = 0; v < 256; v++) begin
          cfg_write(p, 8'(v ^ (m * 37)));
          check_pins("R5 config write (R4 mode)");
        end
    end

    // R6 select 3 ignored
    mode_write(2'b01);
    cfg_write(3, 8'h00);
    check_pins("R6 sel 3 ignored");

    // R8 latch retained through direction change
    cfg_write(1, 8'hFF);
    data_write(8'h06, 8'hC3);
    check_pins("R8 write while input");
    cfg_write(1, 8'h00);
    check_pins("R8 switch to output keeps latch");
    check("R8 port B drives stored", {72'b0, port_slice(pout, 1)}, {72'b0, 8'hC3});

    // R9 mode and config write in one cycle
    @(negedge clk); wdata = 8'hA6; cfg_sel = 2'd2; cfg_we = 1; mode_we = 1;
    @(negedge clk); cfg_we = 0; mode_we = 0;
    apply_cfg(2, 8'hA6); e_mode = 2'b10;
    check_pins("R9 old mode used");
    cfg_write(0, 8'h05);
    check_pins("R9 new mode afterwards");

    // R6 back to none
    mode_write(2'b00);
    cfg_write(1, 8'h5A);
    check_pins("R6 none after use");

    // R7 read path sweeps
    for (int p = 0; p < 3; p++)
      for (int v = 0; v < 256; v++) pin_read(p, 8'(v));
    addr = 8'h04; #1;
    check("R7 other address reads 0", {72'b0, rdata}, 80'b0);
    addr = 8'h08; #1;
    check("R7 other address reads 0", {72'b0, rdata}, 80'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule